// File: doc/BRIEF.md
# Transmit Channel Reconfiguration Reset Sequencer

This block takes a running serial transmit channel and its transmit PLL offline so that the channel can be reconfigured, and then brings both back online in a safe order. When a request arrives and neither calibration engine is busy, the block asserts the PLL power-down, the analog transmit reset and the digital transmit reset together. After a minimum analog dwell it opens a reconfiguration window with a grant output. It holds that window until the reconfiguration logic pulses done.

It then releases power-down and analog reset in the same cycle. It ignores PLL lock for a minimum lock dwell. It releases the digital reset only when the synchronized lock is high and a minimum hold since analog release has passed. The block then returns to idle with a ready flag.

All dwell times are given in microseconds and turned into cycle counts with a clock-frequency parameter in MHz. The lock and the two calibration-busy inputs are asynchronous and pass through two-flop synchronizers. The request is a level that the requester holds until the analog reset rises. The done strobe is synchronous to the block clock.

Top module: `tx_reconfig_seq`

## Requirements
- R1: After reset, power-down, analog reset, digital reset and grant are low and ready is high.
- R2: With the request high in idle and both synchronized busy flags low, the three resets rise together on the next edge and ready falls. A busy input that clears takes effect through two synchronizer flops, so the resets rise on the third edge after the clear.
- R3: While either calibration-busy input is high, a pending request waits in idle with all resets low.
- R4: Grant rises exactly CLK_MHZ*ANA_DWELL_US cycles after the analog reset rises.
- R5: Grant stays high until done is pulsed. On the edge after done, grant falls and power-down and analog reset are released, while the digital reset stays high.
- R6: Analog reset is never released before power-down; both fall on the same edge.
- R7: The digital reset falls on the first edge X at which the synchronized lock was high in the preceding cycle, X is at least CLK_MHZ*DIG_HOLD_US cycles after analog release, and the lock dwell has ended. A lock rising between edges is seen three edges later.
- R8: Lock that is high during the lock dwell, or before the digital hold expires, does not release the digital reset early.
- R9: When the digital reset falls, the block is back in idle with ready high, and a new request starts a new sequence.
- R10: A done pulse outside the reconfiguration window has no effect: resets stay low and ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Reconfiguration request level |
| pll_cal_busy_i | input | 1 | PLL calibration busy (asynchronous) |
| tx_cal_busy_i | input | 1 | Transmit calibration busy (asynchronous) |
| pll_locked_i | input | 1 | Transmit PLL lock (asynchronous) |
| cfg_done_i | input | 1 | One-cycle strobe: reconfiguration finished |
| grant_o | output | 1 | Reconfiguration window open |
| pll_pwrdn_o | output | 1 | PLL power-down |
| tx_ana_rst_o | output | 1 | Analog transmit reset |
| tx_dig_rst_o | output | 1 | Digital transmit reset |
| ready_o | output | 1 | Idle, channel running |

## Verification
Lock arrival and expiry of the digital-reset hold can fall in the same cycle, and they decide together when the digital reset is released. The bench moves the lock edge across offsets that make the synchronized lock arrive one cycle before, exactly at, and one cycle after the hold boundary. It also tests lock that is high throughout and lock that arrives well after the hold. For each case it predicts the release edge as the latest of the hold end, the lock-dwell end and the lock edge plus three cycles. It also sweeps window lengths and clears each busy input while a request is waiting.

// File: rtl/tx_reconfig_pkg.sv
package tx_reconfig_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_DWELL,
    ST_WINDOW,
    ST_LOCK_DWELL,
    ST_LOCK_CHK
  } seq_state_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rsq_timer.sv
module rsq_timer #(
  parameter int CW   = 8,
  parameter int TMAX = 255
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  // saturating up-counter, zero on clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (cnt_q != CW'(TMAX)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tx_reconfig_seq.sv
module tx_reconfig_seq
  import tx_reconfig_pkg::*;
#(
  parameter int CLK_MHZ       = 125,
  parameter int ANA_DWELL_US  = 70,
  parameter int LOCK_DWELL_US = 70,
  parameter int DIG_HOLD_US   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic pll_cal_busy_i,
  input  logic tx_cal_busy_i,
  input  logic pll_locked_i,
  input  logic cfg_done_i,
  output logic grant_o,
  output logic pll_pwrdn_o,
  output logic tx_ana_rst_o,
  output logic tx_dig_rst_o,
  output logic ready_o
);
  localparam int ANA_CYC  = (CLK_MHZ * ANA_DWELL_US  < 1) ? 1 : CLK_MHZ * ANA_DWELL_US;
  localparam int LOCK_CYC = (CLK_MHZ * LOCK_DWELL_US < 1) ? 1 : CLK_MHZ * LOCK_DWELL_US;
  localparam int HOLD_CYC = (CLK_MHZ * DIG_HOLD_US   < 1) ? 1 : CLK_MHZ * DIG_HOLD_US;
  localparam int TMAX_AL  = (ANA_CYC > LOCK_CYC) ? ANA_CYC : LOCK_CYC;
  localparam int TMAX     = (TMAX_AL > HOLD_CYC) ? TMAX_AL : HOLD_CYC;
  localparam int CW       = $clog2(TMAX + 1);

  seq_state_e    state_q, state_d;
  logic [2:0]    async_raw, async_s;
  logic          pll_busy_s, tx_busy_s, lock_s;
  logic          tmr_clr;
  logic [CW-1:0] cnt;
  logic          pwrdn_q, ana_q, dig_q, grant_q, ready_q;

  assign async_raw = {pll_locked_i, tx_cal_busy_i, pll_cal_busy_i};

  rsq_sync #(.WIDTH(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_raw),
    .q_o    (async_s)
  );

  assign pll_busy_s = async_s[0];
  assign tx_busy_s  = async_s[1];
  assign lock_s     = async_s[2];

  // cleared on entry to each dwell; keeps running through lock check to time the digital hold
  assign tmr_clr = (state_d != state_q) &&
                   (state_d == ST_RST_DWELL || state_d == ST_LOCK_DWELL);

  rsq_timer #(.CW(CW), .TMAX(TMAX)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .cnt_o  (cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (req_i && !pll_busy_s && !tx_busy_s) state_d = ST_RST_DWELL;
      ST_RST_DWELL:  if (cnt == CW'(ANA_CYC - 1))            state_d = ST_WINDOW;
      ST_WINDOW:     if (cfg_done_i)                         state_d = ST_LOCK_DWELL;
      ST_LOCK_DWELL: if (cnt == CW'(LOCK_CYC - 1))           state_d = ST_LOCK_CHK;
      ST_LOCK_CHK:   if (lock_s && cnt >= CW'(HOLD_CYC - 1)) state_d = ST_IDLE;
      default:                                               state_d = ST_IDLE;
    endcase
  end

  // outputs registered from next state: glitch-free, no added latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pwrdn_q <= 1'b0;
      ana_q   <= 1'b0;
      dig_q   <= 1'b0;
      grant_q <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      state_q <= state_d;
      pwrdn_q <= (state_d == ST_RST_DWELL) || (state_d == ST_WINDOW);
      ana_q   <= (state_d == ST_RST_DWELL) || (state_d == ST_WINDOW);
      dig_q   <= (state_d != ST_IDLE);
      grant_q <= (state_d == ST_WINDOW);
      ready_q <= (state_d == ST_IDLE);
    end
  end

  assign pll_pwrdn_o  = pwrdn_q;
  assign tx_ana_rst_o = ana_q;
  assign tx_dig_rst_o = dig_q;
  assign grant_o      = grant_q;
  assign ready_o      = ready_q;

  // independent age counters for the dwell checks
  logic [CW-1:0] ana_age_q, rel_age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ana_age_q <= '0;
      rel_age_q <= '0;
    end else begin
      if (!tx_ana_rst_o)                ana_age_q <= '0;
      else if (ana_age_q != CW'(TMAX))  ana_age_q <= ana_age_q + 1'b1;
      if (tx_ana_rst_o || !tx_dig_rst_o) rel_age_q <= '0;
      else if (rel_age_q != CW'(TMAX))   rel_age_q <= rel_age_q + 1'b1;
    end
  end

  // R2
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ana_rst_o) |-> $past(!pll_busy_s && !tx_busy_s));

  // R4
  ana_dwell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> (ana_age_q >= CW'(ANA_CYC)));

  // R5
  grant_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_o) |-> $past(cfg_done_i));

  // R6
  ana_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ana_rst_o) |-> ($past(cfg_done_i) && !pll_pwrdn_o));

  // R7
  dig_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_dig_rst_o) |-> $past(lock_s));

  // R8
  dig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_dig_rst_o) |-> (rel_age_q >= CW'(HOLD_CYC)));
endmodule

// File: tb/sim_tx_reconfig_seq.sv
`timescale 1ns/1ps
module sim_tx_reconfig_seq;
  localparam int MHZ  = 1;
  localparam int ANA  = 70;
  localparam int LOCK = 70;
  localparam int HOLD = 100;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, pll_busy = 1'b0, tx_busy = 1'b0, lock_i = 1'b0, done_i = 1'b0;
  logic grant_o, pwrdn_o, ana_o, dig_o, ready_o;
  int   cyc = 0;
  int   tests = 0, fails = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tx_reconfig_seq #(
    .CLK_MHZ(MHZ), .ANA_DWELL_US(ANA), .LOCK_DWELL_US(LOCK), .DIG_HOLD_US(HOLD)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i),
    .pll_cal_busy_i(pll_busy), .tx_cal_busy_i(tx_busy),
    .pll_locked_i(lock_i), .cfg_done_i(done_i),
    .grant_o(grant_o), .pll_pwrdn_o(pwrdn_o), .tx_ana_rst_o(ana_o),
    .tx_dig_rst_o(dig_o), .ready_o(ready_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // busy_sel: 0 none, 1 pll busy, 2 tx busy; lock_off < 0: lock high throughout
  task automatic run_seq(input int busy_sel, input int lock_off, input int done_dly);
    int t_exp, t_a, t_g, d, l0, x_exp, n;
    bit quiet;
    lock_i = (lock_off < 0);
    if (busy_sel != 0) begin
      pll_busy = (busy_sel == 1);
      tx_busy  = (busy_sel == 2);
      repeat (3) step();
      req_i = 1'b1;
      quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
        step();
        if (ana_o || pwrdn_o || dig_o || !ready_o) quiet = 1'b0;
      end
      chk(quiet, "R3 request held while busy", int'(ana_o), 0);
      pll_busy = 1'b0;
      tx_busy  = 1'b0;
      t_exp = cyc + 3;
    end else begin
      req_i = 1'b1;
      t_exp = cyc + 1;
    end
    n = 0;
    do begin step(); n++; end while (!ana_o && n < 50);
    t_a = cyc;
    req_i = 1'b0;
    chk(t_a == t_exp, "R2 start edge", t_a, t_exp);
    chk(pwrdn_o && dig_o && !ready_o && !grant_o, "R2 resets together",
        {pwrdn_o, dig_o, ready_o, grant_o}, 4'b1100);
    n = 0;
    do begin step(); n++; end while (!grant_o && n < 500);
    t_g = cyc;
    chk(t_g - t_a == ANA * MHZ, "R4 window delay", t_g - t_a, ANA * MHZ);
    repeat (done_dly) step();
    chk(grant_o && ana_o && pwrdn_o, "R5 grant held until done", int'(grant_o), 1);
    done_i = 1'b1;
    d = cyc;
    step();
    done_i = 1'b0;
    chk(cyc == d + 1 && !grant_o && !ana_o && !pwrdn_o && dig_o,
        "R5 R6 release after done", {grant_o, ana_o, pwrdn_o, dig_o}, 4'b0001);
    l0 = cyc;
    x_exp = imax(l0 + HOLD * MHZ, l0 + LOCK * MHZ + 1);
    if (lock_off >= 0) x_exp = imax(x_exp, l0 + lock_off + 3);
    if (lock_off == 0) lock_i = 1'b1;
    do begin
      step();
      if (lock_off > 0 && cyc == l0 + lock_off) lock_i = 1'b1;
    end while (dig_o && cyc < l0 + 400);
    chk(cyc == x_exp, (lock_off <= 97) ? "R8 early lock ignored" : "R7 digital release edge",
        cyc - l0, x_exp - l0);
    chk(ready_o && !ana_o && !pwrdn_o && !grant_o, "R9 back to idle",
        {ready_o, ana_o, pwrdn_o, grant_o}, 4'b1000);
    repeat (2) step();
  endtask

  initial begin
    int offs[8];
    bit quiet;
    offs = '{-1, 0, 50, 96, 97, 98, 99, 150};
    repeat (3) step();
    chk(!ana_o && !pwrdn_o && !dig_o && !grant_o && ready_o, "R1 in reset",
        {ana_o, pwrdn_o, dig_o, grant_o, ready_o}, 5'b00001);
    rst_ni = 1'b1;
    step();
    chk(!ana_o && !pwrdn_o && !dig_o && !grant_o && ready_o, "R1 after reset",
        {ana_o, pwrdn_o, dig_o, grant_o, ready_o}, 5'b00001);
    done_i = 1'b1;
    step();
    done_i = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      if (ana_o || pwrdn_o || dig_o || grant_o || !ready_o) quiet = 1'b0;
    end
    chk(quiet, "R10 stray done ignored", int'(ready_o), 1);
    for (int i = 0; i < 8; i++)
      run_seq((i < 2) ? i + 1 : 0, offs[i], i % 3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule